// File: doc/BRIEF.md
# Legacy INTx Message Request Controller

This block lets software raise and lower a PCIe legacy (virtual-wire) interrupt through a small register set on an AXI4-Lite slave port. Software writes a request code to the control register. The block turns it into one request to a downstream message generator, asking for either an Assert_INTx or a Deassert_INTx message on the selected interrupt line (INTA to INTD). The request bit stays readable as 1 while the generator has not yet taken it, and it clears itself once the generator accepts it. Software polls the register until the bit reads 0.

The block issues requests only while legacy interrupts are allowed. Two configuration-space inputs decide this: the Interrupt Disable bit of the PCI Command register and the MSI Enable bit. A request written while legacy interrupts are blocked is dropped and reported through a sticky flag. The block also records the current virtual-wire level, which is the kind of the last message it completed.

The request leaves the block on a valid/ready handshake. `msg_valid` rises when a request is accepted into the register. `msg_assert` and `msg_pin` are held stable while `msg_valid` is high and `msg_ready` is low. A raised `msg_valid` is never withdrawn. The transfer takes place on the first rising clock edge at which `msg_valid` and `msg_ready` are both high.

Top module: `intx_msg_ctrl`

## Requirements
- R1: After reset both registers read 0, `msg_valid` is 0, and no AXI response is pending.
- R2: When legacy interrupts are enabled and no request is pending, a write of 0x1 to bits[1:0] of the control register (offset 0x0) sets request bit 0. `msg_valid` then goes high from the next cycle, with `msg_assert`=1.
- R3: Under the same conditions, a write of 0x2 sets request bit 1 and raises `msg_valid` with `msg_assert`=0.
- R4: While `msg_valid` is high and `msg_ready` is low, `msg_valid`, `msg_assert` and `msg_pin` hold. On the cycle after `msg_valid` and `msg_ready` are both high, `msg_valid` is 0 and the request bit reads 0.
- R5: Control register bit 2 (read-only) is the wire level. It becomes 1 when an assert request completes and 0 when a deassert request completes.
- R6: Legacy interrupts are blocked while `cfg_intx_disable`=1 or `cfg_msi_enable`=1. A request code written while blocked sets no request bit and never raises `msg_valid`. Instead it sets the sticky dropped flag, control register bit 3.
- R7: Writing 1 to bit 3 clears the dropped flag. If the same write drops a new request, the set wins.
- R8: While a request is pending, the request code of a control write is ignored, and writes to the pin register are ignored.
- R9: The pin register (offset 0x4, bits[1:0]) selects the line: 0=INTA, 1=INTB, 2=INTC, 3=INTD. It reads back and drives `msg_pin`.
- R10: Codes 0x0 and 0x3 request nothing. A write with `s_wstrb[0]`=0 changes no register.
- R11: Every AXI response is OKAY (0). Reads of undefined offsets return 0, and writes to them have no effect. `s_bvalid` and `s_rvalid` (with `s_rdata`) hold until accepted.
- R12: Blocking legacy interrupts while a request is pending does not withdraw it. The request still completes through the handshake.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| s_awvalid | input | 1 | Write address valid |
| s_awready | output | 1 | Write address ready |
| s_awaddr | input | ADDR_W | Write address |
| s_wvalid | input | 1 | Write data valid |
| s_wready | output | 1 | Write data ready |
| s_wdata | input | DATA_W | Write data |
| s_wstrb | input | DATA_W/8 | Write byte strobes |
| s_bvalid | output | 1 | Write response valid |
| s_bready | input | 1 | Write response ready |
| s_bresp | output | 2 | Write response, always OKAY |
| s_arvalid | input | 1 | Read address valid |
| s_arready | output | 1 | Read address ready |
| s_araddr | input | ADDR_W | Read address |
| s_rvalid | output | 1 | Read data valid |
| s_rready | input | 1 | Read data ready |
| s_rdata | output | DATA_W | Read data |
| s_rresp | output | 2 | Read response, always OKAY |
| cfg_intx_disable | input | 1 | Command register Interrupt Disable bit |
| cfg_msi_enable | input | 1 | MSI Enable bit |
| msg_valid | output | 1 | Message request valid |
| msg_ready | input | 1 | Generator accepts the request |
| msg_assert | output | 1 | 1 = Assert_INTx, 0 = Deassert_INTx |
| msg_pin | output | 2 | Interrupt line, 0=INTA to 3=INTD |

## Verification
The bench holds `msg_ready` low for several cycles. A design that let the request fields move, or that dropped `msg_valid`, would show it at the ports before the handshake. Second writes and pin changes are sent while a request is pending; a design that accepted them would change the outstanding message kind or line. Requests are written while each of the two enable inputs blocks issue, including a write that sets and clears the dropped flag at once; a design that leaked a message or let the clear win would read back wrong. A request is also blocked after it has been issued, and a design that withdrew it would never complete it. Codes 0x0 and 0x3, a zero strobe and undefined offsets are exercised so that a loose decode would raise a spurious message.

// File: rtl/intx_pkg.sv
package intx_pkg;
  localparam logic [1:0] CODE_ASSERT   = 2'b01;
  localparam logic [1:0] CODE_DEASSERT = 2'b10;
  localparam int BIT_REQ_ASRT  = 0;
  localparam int BIT_REQ_DASRT = 1;
  localparam int BIT_WIRE      = 2;
  localparam int BIT_DROPPED   = 3;
  localparam int IDX_CTRL = 0;   // word offset 0x0
  localparam int IDX_PIN  = 1;   // word offset 0x4
  localparam logic [1:0] RESP_OKAY = 2'b00;
  typedef logic [1:0] pin_t;
endpackage

// File: rtl/intx_axil_port.sv
module intx_axil_port #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                awvalid,
  output logic                awready,
  input  logic [ADDR_W-1:0]   awaddr,
  input  logic                wvalid,
  output logic                wready,
  input  logic [DATA_W-1:0]   wdata,
  input  logic [DATA_W/8-1:0] wstrb,
  output logic                bvalid,
  input  logic                bready,
  input  logic                arvalid,
  output logic                arready,
  input  logic [ADDR_W-1:0]   araddr,
  output logic                rvalid,
  input  logic                rready,
  output logic [DATA_W-1:0]   rdata,
  output logic                wr_en,
  output logic [ADDR_W-1:0]   wr_addr,
  output logic [DATA_W-1:0]   wr_data,
  output logic [DATA_W/8-1:0] wr_strb,
  output logic [ADDR_W-1:0]   rd_addr,
  input  logic [DATA_W-1:0]   rd_data
);
  logic rd_en;

  // Address and data are taken together, one write at a time.
  assign wr_en   = awvalid && wvalid && !bvalid;
  assign awready = wr_en;
  assign wready  = wr_en;
  assign wr_addr = awaddr;
  assign wr_data = wdata;
  assign wr_strb = wstrb;

  assign arready = !rvalid;
  assign rd_en   = arvalid && !rvalid;
  assign rd_addr = araddr;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bvalid <= 1'b0;
      rvalid <= 1'b0;
      rdata  <= '0;
    end else begin
      if (wr_en) bvalid <= 1'b1;
      else if (bready) bvalid <= 1'b0;
      if (rd_en) begin
        rvalid <= 1'b1;
        rdata  <= rd_data;
      end else if (rready) begin
        rvalid <= 1'b0;
      end
    end
  end

  p_bvalid_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    bvalid && !bready |=> bvalid);
  p_rdata_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    rvalid && !rready |=> rvalid && $stable(rdata));
endmodule

// File: rtl/intx_req_engine.sv
module intx_req_engine
  import intx_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr_en,
  input  logic [ADDR_W-1:0]   wr_addr,
  input  logic [DATA_W-1:0]   wr_data,
  input  logic [DATA_W/8-1:0] wr_strb,
  input  logic                cfg_intx_disable,
  input  logic                cfg_msi_enable,
  output logic                msg_valid,
  input  logic                msg_ready,
  output logic                msg_assert,
  output pin_t                msg_pin,
  output logic                req_asrt,
  output logic                req_dasrt,
  output logic                wire_lvl,
  output logic                dropped,
  output pin_t                pin_sel
);
  localparam int WIDX_W = ADDR_W - 2;

  logic blocked, pending, accept, ctrl_hit, pin_hit, code_ok, new_req;
  logic [1:0] code;

  assign blocked  = cfg_intx_disable || cfg_msi_enable;
  assign pending  = req_asrt || req_dasrt;
  assign accept   = msg_valid && msg_ready;
  assign ctrl_hit = wr_en && wr_strb[0] && (wr_addr[ADDR_W-1:2] == WIDX_W'(IDX_CTRL));
  assign pin_hit  = wr_en && wr_strb[0] && (wr_addr[ADDR_W-1:2] == WIDX_W'(IDX_PIN));
  assign code     = wr_data[1:0];
  assign code_ok  = (code == CODE_ASSERT) || (code == CODE_DEASSERT);
  assign new_req  = ctrl_hit && !pending && code_ok;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      req_asrt  <= 1'b0;
      req_dasrt <= 1'b0;
      wire_lvl  <= 1'b0;
      dropped   <= 1'b0;
      pin_sel   <= '0;
    end else begin
      if (accept) begin
        req_asrt  <= 1'b0;
        req_dasrt <= 1'b0;
        wire_lvl  <= req_asrt;
      end else if (new_req && !blocked) begin
        req_asrt  <= (code == CODE_ASSERT);
        req_dasrt <= (code == CODE_DEASSERT);
      end
      if (new_req && blocked) dropped <= 1'b1;
      else if (ctrl_hit && wr_data[BIT_DROPPED]) dropped <= 1'b0;
      if (pin_hit && !pending) pin_sel <= wr_data[1:0];
    end
  end

  assign msg_valid  = pending;
  assign msg_assert = req_asrt;
  assign msg_pin    = pin_sel;

  p_msg_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    msg_valid && !msg_ready |=> msg_valid && $stable(msg_assert) && $stable(msg_pin));
  p_clear_after_accept_r4: assert property (@(posedge clk) disable iff (!rst_n)
    msg_valid && msg_ready |=> !msg_valid);
  p_wire_follows_r5: assert property (@(posedge clk) disable iff (!rst_n)
    msg_valid && msg_ready |=> wire_lvl == $past(msg_assert));
  p_issue_enabled_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(msg_valid) |-> $past(!blocked));
  p_one_outstanding_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({req_asrt, req_dasrt}));
endmodule

// File: rtl/intx_csr_mux.sv
module intx_csr_mux
  import intx_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32
) (
  input  logic [ADDR_W-1:0] rd_addr,
  input  logic              req_asrt,
  input  logic              req_dasrt,
  input  logic              wire_lvl,
  input  logic              dropped,
  input  pin_t              pin_sel,
  output logic [DATA_W-1:0] rd_data
);
  localparam int WIDX_W = ADDR_W - 2;
  logic [WIDX_W-1:0] widx;
  assign widx = rd_addr[ADDR_W-1:2];

  always_comb begin
    rd_data = '0;
    if (widx == WIDX_W'(IDX_CTRL)) begin
      rd_data[BIT_REQ_ASRT]  = req_asrt;
      rd_data[BIT_REQ_DASRT] = req_dasrt;
      rd_data[BIT_WIRE]      = wire_lvl;
      rd_data[BIT_DROPPED]   = dropped;
    end else if (widx == WIDX_W'(IDX_PIN)) begin
      rd_data[1:0] = pin_sel;
    end
  end
endmodule

// File: rtl/intx_msg_ctrl.sv
module intx_msg_ctrl
  import intx_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                s_awvalid,
  output logic                s_awready,
  input  logic [ADDR_W-1:0]   s_awaddr,
  input  logic                s_wvalid,
  output logic                s_wready,
  input  logic [DATA_W-1:0]   s_wdata,
  input  logic [DATA_W/8-1:0] s_wstrb,
  output logic                s_bvalid,
  input  logic                s_bready,
  output logic [1:0]          s_bresp,
  input  logic                s_arvalid,
  output logic                s_arready,
  input  logic [ADDR_W-1:0]   s_araddr,
  output logic                s_rvalid,
  input  logic                s_rready,
  output logic [DATA_W-1:0]   s_rdata,
  output logic [1:0]          s_rresp,
  input  logic                cfg_intx_disable,
  input  logic                cfg_msi_enable,
  output logic                msg_valid,
  input  logic                msg_ready,
  output logic                msg_assert,
  output logic [1:0]          msg_pin
);
  logic                wr_en;
  logic [ADDR_W-1:0]   wr_addr, rd_addr;
  logic [DATA_W-1:0]   wr_data, rd_data;
  logic [DATA_W/8-1:0] wr_strb;
  logic                req_asrt, req_dasrt, wire_lvl, dropped;
  pin_t                pin_sel;

  assign s_bresp = RESP_OKAY;
  assign s_rresp = RESP_OKAY;

  intx_axil_port #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_port (
    .clk(clk), .rst_n(rst_n),
    .awvalid(s_awvalid), .awready(s_awready), .awaddr(s_awaddr),
    .wvalid(s_wvalid), .wready(s_wready), .wdata(s_wdata), .wstrb(s_wstrb),
    .bvalid(s_bvalid), .bready(s_bready),
    .arvalid(s_arvalid), .arready(s_arready), .araddr(s_araddr),
    .rvalid(s_rvalid), .rready(s_rready), .rdata(s_rdata),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data), .wr_strb(wr_strb),
    .rd_addr(rd_addr), .rd_data(rd_data)
  );

  intx_req_engine #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_engine (
    .clk(clk), .rst_n(rst_n),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data), .wr_strb(wr_strb),
    .cfg_intx_disable(cfg_intx_disable), .cfg_msi_enable(cfg_msi_enable),
    .msg_valid(msg_valid), .msg_ready(msg_ready), .msg_assert(msg_assert),
    .msg_pin(msg_pin), .req_asrt(req_asrt), .req_dasrt(req_dasrt),
    .wire_lvl(wire_lvl), .dropped(dropped), .pin_sel(pin_sel)
  );

  intx_csr_mux #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_mux (
    .rd_addr(rd_addr), .req_asrt(req_asrt), .req_dasrt(req_dasrt),
    .wire_lvl(wire_lvl), .dropped(dropped), .pin_sel(pin_sel), .rd_data(rd_data)
  );
endmodule

// File: tb/test_intx_msg_ctrl.sv
module test_intx_msg_ctrl;
  logic clk = 1'b0, rst_n = 1'b0;
  logic awvalid = 0, wvalid = 0, bready = 0, arvalid = 0, rready = 0;
  logic [7:0] awaddr = 0, araddr = 0;
  logic [31:0] wdata = 0;
  logic [3:0] wstrb = 0;
  logic awready, wready, bvalid, arready, rvalid;
  logic [1:0] bresp, rresp, msg_pin;
  logic [31:0] rdata;
  logic cfg_dis = 0, cfg_msi = 0, msg_ready = 0, msg_valid, msg_assert;
  int total = 0, bad = 0;
  bit done = 0;

  always #5 clk = ~clk;

  intx_msg_ctrl i_intx_msg_ctrl (
    .clk(clk), .rst_n(rst_n),
    .s_awvalid(awvalid), .s_awready(awready), .s_awaddr(awaddr),
    .s_wvalid(wvalid), .s_wready(wready), .s_wdata(wdata), .s_wstrb(wstrb),
    .s_bvalid(bvalid), .s_bready(bready), .s_bresp(bresp),
    .s_arvalid(arvalid), .s_arready(arready), .s_araddr(araddr),
    .s_rvalid(rvalid), .s_rready(rready), .s_rdata(rdata), .s_rresp(rresp),
    .cfg_intx_disable(cfg_dis), .cfg_msi_enable(cfg_msi),
    .msg_valid(msg_valid), .msg_ready(msg_ready),
    .msg_assert(msg_assert), .msg_pin(msg_pin)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic axi_wr(input logic [7:0] a, input logic [31:0] d, input logic [3:0] s);
    @(negedge clk);
    awvalid = 1; awaddr = a; wvalid = 1; wdata = d; wstrb = s;
    @(posedge clk);
    @(negedge clk);
    awvalid = 0; wvalid = 0;
    chk("R11 bvalid", {31'b0, bvalid}, 1);
    chk("R11 bresp", {30'b0, bresp}, 0);
    bready = 1;
    @(posedge clk);
    @(negedge clk);
    bready = 0;
  endtask

  task automatic axi_rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    arvalid = 1; araddr = a;
    @(posedge clk);
    @(negedge clk);
    arvalid = 0;
    d = rdata;
    @(posedge clk);
    @(negedge clk);
    chk("R11 rdata held", rdata, d);
    chk("R11 rresp", {30'b0, rresp}, 0);
    rready = 1;
    @(posedge clk);
    @(negedge clk);
    rready = 0;
  endtask

  task automatic rd_chk(input string tag, input logic [7:0] a, input logic [31:0] exp);
    logic [31:0] v;
    axi_rd(a, v);
    chk(tag, v, exp);
  endtask

  task automatic complete(input string tag);
    msg_ready = 1;
    @(posedge clk);
    @(negedge clk);
    msg_ready = 0;
    chk(tag, {31'b0, msg_valid}, 0);
  endtask

  task automatic t_reset;
    chk("R1 msg_valid", {31'b0, msg_valid}, 0);
    chk("R1 bvalid", {31'b0, bvalid}, 0);
    chk("R1 rvalid", {31'b0, rvalid}, 0);
    rd_chk("R1 ctrl", 8'h00, 0);
    rd_chk("R1 pin", 8'h04, 0);
  endtask

  task automatic t_assert_flow;
    axi_wr(8'h04, 2, 4'hF);
    rd_chk("R9 pin readback", 8'h04, 2);
    axi_wr(8'h00, 1, 4'hF);
    chk("R2 msg_valid", {31'b0, msg_valid}, 1);
    chk("R2 msg_assert", {31'b0, msg_assert}, 1);
    chk("R9 msg_pin", {30'b0, msg_pin}, 2);
    rd_chk("R2 ctrl pending", 8'h00, 1);
    repeat (3) @(negedge clk);
    chk("R4 valid held", {31'b0, msg_valid}, 1);
    chk("R4 assert held", {31'b0, msg_assert}, 1);
    chk("R4 pin held", {30'b0, msg_pin}, 2);
    complete("R4 cleared after accept");
    rd_chk("R5 wire set", 8'h00, 4);
  endtask

  task automatic t_deassert_flow;
    axi_wr(8'h00, 2, 4'hF);
    chk("R3 msg_valid", {31'b0, msg_valid}, 1);
    chk("R3 msg_assert", {31'b0, msg_assert}, 0);
    rd_chk("R3 ctrl pending", 8'h00, 6);
    complete("R4 cleared after deassert");
    rd_chk("R5 wire cleared", 8'h00, 0);
  endtask

  task automatic t_gating;
    cfg_dis = 1;
    axi_wr(8'h00, 1, 4'hF);
    repeat (2) @(negedge clk);
    chk("R6 no issue intx_disable", {31'b0, msg_valid}, 0);
    rd_chk("R6 dropped set", 8'h00, 8);
    axi_wr(8'h00, 8, 4'hF);
    rd_chk("R7 dropped cleared", 8'h00, 0);
    cfg_dis = 0; cfg_msi = 1;
    axi_wr(8'h00, 2, 4'hF);
    chk("R6 no issue msi", {31'b0, msg_valid}, 0);
    rd_chk("R6 dropped by msi", 8'h00, 8);
    axi_wr(8'h00, 9, 4'hF);
    rd_chk("R7 set wins", 8'h00, 8);
    axi_wr(8'h00, 8, 4'hF);
    rd_chk("R7 cleared again", 8'h00, 0);
    cfg_msi = 0;
  endtask

  task automatic t_pending_ignore;
    axi_wr(8'h04, 1, 4'hF);
    axi_wr(8'h00, 1, 4'hF);
    axi_wr(8'h00, 2, 4'hF);
    rd_chk("R8 second code ignored", 8'h00, 1);
    chk("R8 kind kept", {31'b0, msg_assert}, 1);
    axi_wr(8'h04, 3, 4'hF);
    rd_chk("R8 pin write ignored", 8'h04, 1);
    chk("R8 msg_pin kept", {30'b0, msg_pin}, 1);
    complete("R8 complete");
    rd_chk("R8 after complete", 8'h00, 4);
    axi_wr(8'h00, 2, 4'hF);
    complete("R8 deassert complete");
    rd_chk("R8 wire low", 8'h00, 0);
  endtask

  task automatic t_disable_while_pending;
    axi_wr(8'h00, 1, 4'hF);
    cfg_dis = 1;
    repeat (2) @(negedge clk);
    chk("R12 still valid", {31'b0, msg_valid}, 1);
    complete("R12 completes");
    rd_chk("R12 wire set no drop", 8'h00, 4);
    cfg_dis = 0;
    axi_wr(8'h00, 2, 4'hF);
    complete("R12 deassert");
    rd_chk("R12 wire low", 8'h00, 0);
  endtask

  task automatic t_bad_codes;
    axi_wr(8'h00, 0, 4'hF);
    chk("R10 code0 no msg", {31'b0, msg_valid}, 0);
    axi_wr(8'h00, 3, 4'hF);
    chk("R10 code3 no msg", {31'b0, msg_valid}, 0);
    axi_wr(8'h00, 1, 4'h0);
    chk("R10 zero strobe no msg", {31'b0, msg_valid}, 0);
    rd_chk("R10 ctrl unchanged", 8'h00, 0);
  endtask

  task automatic t_undefined;
    rd_chk("R11 undef 0x8", 8'h08, 0);
    rd_chk("R11 undef 0xC", 8'h0C, 0);
    axi_wr(8'h08, 1, 4'hF);
    chk("R11 undef write no msg", {31'b0, msg_valid}, 0);
    rd_chk("R11 ctrl intact", 8'h00, 0);
  endtask

  task automatic t_pin_all;
    for (int p = 0; p < 4; p++) begin
      axi_wr(8'h04, p, 4'hF);
      axi_wr(8'h00, 1, 4'hF);
      chk("R9 line on assert", {30'b0, msg_pin}, p);
      complete("R9 assert done");
      axi_wr(8'h00, 2, 4'hF);
      chk("R9 line on deassert", {30'b0, msg_pin}, p);
      complete("R9 deassert done");
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset;
    t_assert_flow;
    t_deassert_flow;
    t_gating;
    t_pending_ignore;
    t_disable_while_pending;
    t_bad_codes;
    t_undefined;
    t_pin_all;
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule